// File: doc/BRIEF.md
# Multi-Channel DMA Priority Arbiter

This block decides which of up to eight DMA channels gets the bus next. Each cycle it looks at a vector of per-channel requests and a two-bit policy code. When the global enable is set and no grant is outstanding, it registers a one-hot grant, an index and a valid flag. Three policy codes select fixed rankings. In two of these, the channels are permuted inside each group of four, so the ranking is not monotonic. The fourth code selects a two-tier rotating scheme.

The winning channel holds the grant until it pulses the done strobe. On the edge that samples done, the grant is released and the rotation pointer of the granted channel's tier moves one place past that channel. Arbitration runs again on the edge after that, so a released grant is always followed by at least one idle cycle. The number of implemented channels is a parameter. Request lines at or above that number never win.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is asserted, and after it is released, no grant is valid and `gnt_o` is zero. Both rotation pointers start at the first channel of their tier: channel 0 for the high tier and channel 4 for the low tier.
- R2: While `gnt_valid_o` is high, `gnt_o` has exactly one bit set, and `gnt_id_o` is the index of that bit. A new grant goes only to a channel whose request was high in the cycle before the grant appeared.
- R3: Policy code 0 ranks the channels from highest to lowest as 0,1,2,3,4,5,6,7.
- R4: Policy code 1 ranks the channels from highest to lowest as 0,2,3,1,4,6,7,5.
- R5: Policy code 2 ranks the channels from highest to lowest as 2,0,1,3,6,4,5,7.
- R6: Policy code 3 is tiered round robin. Any request from channels 0–3 wins over every request from channels 4–7.
- R7: Each tier has its own rotation pointer. Under code 3, the winner in a tier is the first requesting channel found by starting at that tier's pointer and wrapping around within the tier. Whatever the policy, an accepted grant moves the pointer of the granted channel's tier to the next channel, wrapping from the last channel of the tier to its first.
- R8: While `enable_i` is low, no new grant is issued. A grant already outstanding stays until done.
- R9: A grant holds its value until `done_i` is sampled high. `gnt_valid_o` is low after that edge, and the next grant is evaluated on the following edge. If `done_i` is high when no grant is outstanding, it has no effect.
- R10: Request bits at index `NUM_CH` or higher are never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Per-channel request, bit n for channel n |
| policy_i | input | 2 | Policy code (0–2 fixed rankings, 3 tiered round robin) |
| enable_i | input | 1 | Global enable for issuing grants |
| done_i | input | 1 | Accept/done strobe from the granted channel |
| gnt_o | output | 8 | One-hot grant |
| gnt_valid_o | output | 1 | Grant outstanding |
| gnt_id_o | output | 3 | Index of the granted channel |

## Verification
Two things can happen on the same edge: the current grant is released, and the inputs that choose the next winner change. To provoke this, the bench holds a low-ranked grant and raises higher-ranked requests. In the cycle where done is asserted, it also switches the policy code, or drops the enable. The check has two parts. The release must leave the bus idle for exactly one cycle. The next grant must then follow the new policy and enable values, not the values that were in effect when the old grant was made. The rotation tests also confirm that each accept moves only the pointer of the granted channel's tier.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int unsigned MAX_CH     = 8;
    localparam int unsigned CH_IDX_W   = $clog2(MAX_CH);
    localparam int unsigned TIER_CH    = MAX_CH / 2;
    localparam int unsigned TIER_IDX_W = $clog2(TIER_CH);
    localparam int unsigned NUM_TIERS  = 2;

    typedef enum logic [1:0] {
        POL_LINEAR = 2'd0,
        POL_PERM_A = 2'd1,
        POL_PERM_B = 2'd2,
        POL_ROUND  = 2'd3
    } arb_policy_e;

    typedef struct packed {
        logic [MAX_CH-1:0]                         gnt;
        logic [CH_IDX_W-1:0]                       gnt_id;
        logic                                      valid;
        logic [NUM_TIERS-1:0][TIER_IDX_W-1:0]      ptr;
    } arb_state_t;

    // Channel at a given rank position under a fixed policy.
    // Both groups of four use the same inner permutation.
    function automatic logic [CH_IDX_W-1:0] rank_to_ch(
        input logic [1:0]          pol,
        input logic [CH_IDX_W-1:0] pos
    );
        logic [TIER_IDX_W-1:0] sub;
        sub = pos[TIER_IDX_W-1:0];
        case (pol)
            POL_PERM_A: begin
                case (pos[TIER_IDX_W-1:0])
                    2'd0:    sub = 2'd0;
                    2'd1:    sub = 2'd2;
                    2'd2:    sub = 2'd3;
                    default: sub = 2'd1;
                endcase
            end
            POL_PERM_B: begin
                case (pos[TIER_IDX_W-1:0])
                    2'd0:    sub = 2'd2;
                    2'd1:    sub = 2'd0;
                    2'd2:    sub = 2'd1;
                    default: sub = 2'd3;
                endcase
            end
            default: sub = pos[TIER_IDX_W-1:0];
        endcase
        return {pos[CH_IDX_W-1], sub};
    endfunction

endpackage

// File: rtl/dma_arb_fixed.sv
module dma_arb_fixed
    import dma_arb_pkg::*;
(
    input  logic [MAX_CH-1:0]   req_i,
    input  logic [1:0]          policy_i,
    output logic                any_o,
    output logic [CH_IDX_W-1:0] idx_o
);

    logic [CH_IDX_W-1:0] cand;

    // Scan from lowest rank to highest: the last hit is the winner.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        cand  = '0;
        for (int p = MAX_CH - 1; p >= 0; p--) begin
            cand = rank_to_ch(policy_i, CH_IDX_W'(p));
            if (req_i[cand]) begin
                any_o = 1'b1;
                idx_o = cand;
            end
        end
    end

endmodule

// File: rtl/dma_arb_rr_tier.sv
module dma_arb_rr_tier #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] ptr_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    logic [IW-1:0] cand;

    // Walk from the farthest offset back to the pointer; the nearest hit wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        cand  = '0;
        for (int k = int'(N) - 1; k >= 0; k--) begin
            cand = ptr_i + IW'(k);
            if (req_i[cand]) begin
                any_o = 1'b1;
                idx_o = cand;
            end
        end
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [MAX_CH-1:0]   req_i,
    input  logic [1:0]          policy_i,
    input  logic                enable_i,
    input  logic                done_i,
    output logic [MAX_CH-1:0]   gnt_o,
    output logic                gnt_valid_o,
    output logic [CH_IDX_W-1:0] gnt_id_o
);

    localparam int unsigned EFF_CH = (NUM_CH > MAX_CH) ? MAX_CH : NUM_CH;

    logic [MAX_CH-1:0] ch_mask;
    logic [MAX_CH-1:0] req_eff;

    generate
        for (genvar c = 0; c < MAX_CH; c++) begin : g_mask
            assign ch_mask[c] = (c < EFF_CH);
        end
    endgenerate

    assign req_eff = req_i & ch_mask;

    // Fixed-order picker
    logic                fix_any;
    logic [CH_IDX_W-1:0] fix_idx;

    dma_arb_fixed u_fixed (
        .req_i    (req_eff),
        .policy_i (policy_i),
        .any_o    (fix_any),
        .idx_o    (fix_idx)
    );

    // Round-robin pickers, one per tier
    arb_state_t s_q, s_d;

    logic [NUM_TIERS-1:0]                  tier_any;
    logic [NUM_TIERS-1:0][TIER_IDX_W-1:0]  tier_idx;

    generate
        for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
            dma_arb_rr_tier #(
                .N  (TIER_CH),
                .IW (TIER_IDX_W)
            ) u_tier (
                .req_i (req_eff[t*TIER_CH +: TIER_CH]),
                .ptr_i (s_q.ptr[t]),
                .any_o (tier_any[t]),
                .idx_o (tier_idx[t])
            );
        end
    endgenerate

    logic                win_any;
    logic [CH_IDX_W-1:0] win_idx;

    always_comb begin
        win_any = 1'b0;
        win_idx = '0;
        if (policy_i == POL_ROUND) begin
            if (tier_any[0]) begin
                win_any = 1'b1;
                win_idx = {1'b0, tier_idx[0]};
            end else if (tier_any[1]) begin
                win_any = 1'b1;
                win_idx = {1'b1, tier_idx[1]};
            end
        end else begin
            win_any = fix_any;
            win_idx = fix_idx;
        end
    end

    // Next-state logic
    always_comb begin
        s_d = s_q;
        if (s_q.valid) begin
            if (done_i) begin
                s_d.valid = 1'b0;
                s_d.gnt   = '0;
                s_d.ptr[s_q.gnt_id[CH_IDX_W-1]] =
                    s_q.gnt_id[TIER_IDX_W-1:0] + TIER_IDX_W'(1);
            end
        end else if (enable_i && win_any) begin
            s_d.valid  = 1'b1;
            s_d.gnt_id = win_idx;
            s_d.gnt    = MAX_CH'(1) << win_idx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt_o       = s_q.gnt;
    assign gnt_valid_o = s_q.valid;
    assign gnt_id_o    = s_q.gnt_id;

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [MAX_CH-1:0]   req_i,
    input logic [1:0]          policy_i,
    input logic                enable_i,
    input logic                done_i,
    input logic [MAX_CH-1:0]   gnt_o,
    input logic                gnt_valid_o,
    input logic [CH_IDX_W-1:0] gnt_id_o
);

    p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(gnt_o) == (gnt_valid_o ? 1 : 0));

    p_id_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_valid_o |-> gnt_o[gnt_id_o]);

    p_was_requested_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gnt_valid_o) |-> |(gnt_o & $past(req_i)));

    p_high_tier_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(gnt_valid_o) && $past(policy_i) == 2'd3 && |$past(req_i[3:0]))
            |-> !gnt_id_o[CH_IDX_W-1]);

    p_no_grant_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!gnt_valid_o && !enable_i) |=> !gnt_valid_o);

    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_valid_o && !done_i) |=> (gnt_valid_o && $stable(gnt_o)));

    p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_valid_o && done_i) |=> !gnt_valid_o);

    p_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_valid_o |-> (int'(gnt_id_o) < int'(NUM_CH)));

endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .policy_i    (policy_i),
    .enable_i    (enable_i),
    .done_i      (done_i),
    .gnt_o       (gnt_o),
    .gnt_valid_o (gnt_valid_o),
    .gnt_id_o    (gnt_id_o)
);

// File: tb/dma_prio_arb_tb.sv
module dma_prio_arb_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic [1:0] policy = '0;
    logic       enable = 1'b0;
    logic       done = 1'b0;
    logic [7:0] gnt, gnt6;
    logic       valid, valid6;
    logic [2:0] gid, gid6;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_prio_arb #(.NUM_CH(8)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .policy_i(policy),
        .enable_i(enable), .done_i(done),
        .gnt_o(gnt), .gnt_valid_o(valid), .gnt_id_o(gid)
    );

    dma_prio_arb #(.NUM_CH(6)) u_dut_n6 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .policy_i(policy),
        .enable_i(enable), .done_i(done),
        .gnt_o(gnt6), .gnt_valid_o(valid6), .gnt_id_o(gid6)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; policy = '0; enable = 1'b1; done = 1'b0;
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic grant_is(input string tag, input int ch);
        check({tag, " valid"}, {31'd0, valid}, 32'd1);
        check({tag, " gnt"}, {24'd0, gnt}, 32'd1 << ch);
        check({tag, " id"}, {29'd0, gid}, ch);
    endtask

    task automatic accept();
        done = 1'b1;
        step();
        done = 1'b0;
        check("R9 release", {31'd0, valid}, 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; enable = 1'b1; req = 8'hFF;
        step();
        check("R1 gnt in reset", {24'd0, gnt}, 0);
        check("R1 valid in reset", {31'd0, valid}, 0);
        req = '0;
        rst_n = 1'b1;
        step();
        check("R1 valid after reset", {31'd0, valid}, 0);
    endtask

    task automatic t_policy0();
        do_reset();
        policy = 2'd0; req = 8'h60;
        step(); grant_is("R3 {5,6}", 5); accept();
        req = 8'hFF;
        step(); grant_is("R3 all", 0); accept();
        req = '0; step();
    endtask

    task automatic t_policy1();
        do_reset();
        policy = 2'd1; req = 8'hA2;
        step(); grant_is("R4 {1,5,7}", 1); accept();
        req = 8'hA0;
        step(); grant_is("R4 {5,7}", 7); accept();
        req = 8'h0A;
        step(); grant_is("R4 {1,3}", 3); accept();
        req = '0; step();
    endtask

    task automatic t_policy2();
        do_reset();
        policy = 2'd2; req = 8'h0B;
        step(); grant_is("R5 {0,1,3}", 0); accept();
        req = 8'h0A;
        step(); grant_is("R5 {1,3}", 1); accept();
        req = 8'h90;
        step(); grant_is("R5 {4,7}", 4); accept();
        req = '0; step();
    endtask

    task automatic t_round();
        do_reset();
        policy = 2'd3; req = 8'hFF;
        step(); grant_is("R7 rr 0", 0); accept();
        step(); grant_is("R7 rr 1", 1); accept();
        step(); grant_is("R7 rr 2", 2); accept();
        step(); grant_is("R7 rr 3", 3); accept();
        step(); grant_is("R7 rr wrap", 0); accept();
        req = 8'hF0;
        step(); grant_is("R7 low tier 4", 4); accept();
        step(); grant_is("R7 low tier 5", 5); accept();
        req = 8'h44;
        step(); grant_is("R6 high tier first", 2); accept();
        req = 8'h0A;
        step(); grant_is("R7 ptr past 2", 3); accept();
        step(); grant_is("R7 ptr wraps", 1); accept();
        req = 8'hC0;
        step(); grant_is("R7 low ptr kept", 6); accept();
        req = '0; step();
    endtask

    task automatic t_enable();
        do_reset();
        policy = 2'd0; enable = 1'b0; req = 8'hFF;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R8 no grant disabled", {31'd0, valid}, 0);
        end
        enable = 1'b1;
        step(); grant_is("R8 after enable", 0);
        enable = 1'b0;
        step(); grant_is("R8 held while disabled", 0);
        accept();
        step();
        check("R8 none after release", {31'd0, valid}, 0);
        enable = 1'b1; req = '0; step();
    endtask

    task automatic t_hold();
        do_reset();
        policy = 2'd0; req = 8'h80;
        step(); grant_is("R9 first", 7);
        req = 8'hFF;
        for (int i = 0; i < 3; i++) begin
            step(); grant_is("R9 held", 7);
        end
        policy = 2'd2; done = 1'b1;
        step();
        done = 1'b0;
        check("R9 idle after done", {31'd0, valid}, 0);
        step(); grant_is("R9 new policy used", 2);
        accept();
        req = '0; done = 1'b1;
        step();
        done = 1'b0;
        check("R9 stray done", {31'd0, valid}, 0);
        req = 8'h10; policy = 2'd3;
        step(); grant_is("R9 stray done no ptr move", 4);
        accept();
        req = '0; step();
    endtask

    task automatic t_mask();
        do_reset();
        policy = 2'd0; req = 8'hC0;
        step();
        grant_is("R10 full width", 6);
        check("R10 n6 ignores 6,7", {31'd0, valid6}, 0);
        accept();
        req = 8'hE0;
        step();
        check("R10 n6 grants 5", {24'd0, gnt6}, 32'h20);
        check("R10 n6 valid", {31'd0, valid6}, 1);
        req = '0; done = 1'b1; step(); done = 1'b0; step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_policy0();
        t_policy1();
        t_policy2();
        t_round();
        t_enable();
        t_hold();
        t_mask();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule